// File: doc/BRIEF.md
# Boot ROM Width Detector

This block decides how wide the boot ROM in bank 0 is before any software has run. A single asynchronous strap pin is observed twice: once while the chip is held in reset and once a fixed number of clocks after reset is released. The pair of observed levels selects an 8-, 16- or 32-bit width. A strap wired straight to the active-low reset pin reads low during reset and high afterwards, so that wiring selects the 8-bit width without any extra board parts. The pin may rise slowly, so it passes through a chain of flip-flops before either observation is taken.

The external memory controller reads a 2-bit width code and a valid flag. Once initialization software has programmed the ROM configuration, it issues a one-cycle configuration write. The written width replaces the strapped one from the next clock until the next reset.

Top module: `boot_width_det`

## Requirements
- R1: The strap passes through a SYNC_STAGES-deep flip-flop chain. The during-reset observation is the chain output at the last clock edge that sees `rst` high. The strap must be held steady for at least SYNC_STAGES edges of reset.
- R2: Strap high during reset and high after release gives width code 2'b10, meaning 32-bit.
- R3: Strap low during reset and low after release gives width code 2'b01, meaning 16-bit.
- R4: Strap low during reset and high after release gives width code 2'b00, meaning 8-bit. This is the case of a strap tied to the active-low reset line.
- R5: The unused pair, high during reset and low after release, gives 2'b10 (32-bit).
- R6: While `rst` is high, and up to the SETTLE_CYC-th rising edge after `rst` falls, `width_valid` is 0 and `width_code` is 2'b10. At that edge the post-release observation is taken and `width_valid` rises.
- R7: A clock edge with `cfg_wr` high loads `cfg_width`. The result shows on `width_code` with `width_valid` high from that edge on, even if the strap observation has not been taken yet.
- R8: After a configuration write, strap changes have no effect on `width_code` until the next reset. A reset drops the configured value, and the strap decides the width again.
- R9: A configuration write of 2'b11 is stored as 2'b10 (32-bit).
- R10: `width_code` never reads 2'b11. Once `width_valid` is high, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_in | input | 1 | Asynchronous boot-width strap pin |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_width | input | 2 | Width code carried by the configuration write |
| width_code | output | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit |
| width_valid | output | 1 | High once the width is known (strap observed or configured) |

## Verification
The bench builds the block with its defaults: three synchronizer stages and a settle delay of four clocks. The synchronizer latency is then shorter than the settle delay, so a strap that changes level exactly when reset is released is already visible when the post-release observation is taken. With these values the tied-to-reset case, the cycle before and the cycle of the valid edge, and a configuration write that lands before the strap observation can all be placed on exact cycles.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [1:0] {
        BW_8  = 2'b00,
        BW_16 = 2'b01,
        BW_32 = 2'b10
    } bw_code_e;

    // Width used before anything is known, and for the unused strap pair
    localparam bw_code_e BW_DEFAULT = BW_32;

    // Map (level during reset, level after release) to a width
    function automatic bw_code_e strap_decode(input logic lvl_in_rst, input logic lvl_after);
        bw_code_e w;
        case ({lvl_in_rst, lvl_after})
            2'b11:   w = BW_32;
            2'b00:   w = BW_16;
            2'b01:   w = BW_8;
            default: w = BW_DEFAULT;
        endcase
        return w;
    endfunction

    // Turn a raw software code into a legal width
    function automatic bw_code_e cfg_clean(input logic [1:0] raw);
        bw_code_e w;
        case (raw)
            2'b00:   w = BW_8;
            2'b01:   w = BW_16;
            default: w = BW_32;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    // No reset: the chain must keep tracking the pin while reset is held
    logic [STAGES-1:0] stg;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) stg[0] <= d_async;
            end else begin : g_next
                always_ff @(posedge clk) stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/bwd_sampler.sv
module bwd_sampler
    import bwd_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    output logic     done,
    output bw_code_e strap_code
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic             lvl_rst_q;
    logic [CNT_W-1:0] wait_cnt;

    // Keep following the synchronized pin while reset is held
    always_ff @(posedge clk) begin
        if (rst) lvl_rst_q <= lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt   <= '0;
            done       <= 1'b0;
            strap_code <= BW_DEFAULT;
        end else if (!done) begin
            wait_cnt <= wait_cnt + 1'b1;
            if (wait_cnt == LAST) begin
                done       <= 1'b1;
                strap_code <= strap_decode(lvl_rst_q, lvl);
            end
        end
    end
endmodule

// File: rtl/bwd_override.sv
module bwd_override
    import bwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] wdata,
    output logic       active,
    output bw_code_e   code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            code   <= BW_DEFAULT;
        end else if (wr) begin
            active <= 1'b1;
            code   <= cfg_clean(wdata);
        end
    end
endmodule

// File: rtl/boot_width_det.sv
module boot_width_det
    import bwd_pkg::*;
#(
    parameter int SYNC_STAGES = 3,
    parameter int SETTLE_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_in,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_width,
    output logic [1:0] width_code,
    output logic       width_valid
);
    logic     strap_s;
    logic     smp_done;
    bw_code_e smp_code;
    logic     ovr_on;
    bw_code_e ovr_code;

    bwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .d_async (strap_in),
        .q_sync  (strap_s)
    );

    bwd_sampler #(.SETTLE_CYC(SETTLE_CYC)) u_smp (
        .clk        (clk),
        .rst        (rst),
        .lvl        (strap_s),
        .done       (smp_done),
        .strap_code (smp_code)
    );

    bwd_override u_ovr (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .wdata  (cfg_width),
        .active (ovr_on),
        .code   (ovr_code)
    );

    always_comb begin
        if (ovr_on)        width_code = ovr_code;
        else if (smp_done) width_code = smp_code;
        else               width_code = BW_DEFAULT;
    end

    assign width_valid = ovr_on | smp_done;
endmodule

// File: rtl/bwd_chk.sv
module bwd_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic [1:0] cfg_width,
    input logic [1:0] width_code,
    input logic       width_valid
);
    // R10
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        width_code != 2'b11);

    // R10
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        width_valid |=> width_valid);

    // R7
    cfg_applied_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (width_valid &&
                    width_code == (($past(cfg_width) == 2'b11) ? 2'b10 : $past(cfg_width))));

    // R8
    code_held_chk: assert property (@(posedge clk) disable iff (rst)
        (width_valid && !cfg_wr) |=> $stable(width_code));
endmodule

bind boot_width_det bwd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_width   (cfg_width),
    .width_code  (width_code),
    .width_valid (width_valid)
);

// File: tb/boot_width_det_tb.sv
module boot_width_det_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_in = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_width = 2'b00;
    logic [1:0] width_code;
    logic       width_valid;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int         at;
        logic [1:0] code;
        logic       vld;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    boot_width_det u_dut (
        .clk         (clk),
        .rst         (rst),
        .strap_in    (strap_in),
        .cfg_wr      (cfg_wr),
        .cfg_width   (cfg_width),
        .width_code  (width_code),
        .width_valid (width_valid)
    );

    task automatic expect_at(input int at, input logic [1:0] code, input logic vld, input string tag);
        exp_t e;
        e.at = at; e.code = code; e.vld = vld; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare at falling edges
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (width_code !== e.code || width_valid !== e.vld) begin
                n_bad++;
                $display("FAIL %s: code=%b valid=%b expected code=%b valid=%b",
                         e.tag, width_code, width_valid, e.code, e.vld);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold reset with level lvl_rst, release with level lvl_after
    task automatic boot(input logic lvl_rst, input logic lvl_after,
                        input logic [1:0] exp_code, input string tag);
        int c;
        @(negedge clk);
        rst = 1'b1; strap_in = lvl_rst;
        expect_at(cyc + 3, 2'b10, 1'b0, "R6 in reset");
        idle(6);
        c = cyc;
        rst = 1'b0; strap_in = lvl_after;
        expect_at(c + 3, 2'b10, 1'b0, "R6 edge before sample");
        expect_at(c + 4, exp_code, 1'b1, tag);
        idle(6);
    endtask

    task automatic cfg_write(input logic [1:0] v, input logic [1:0] exp_code, input string tag);
        int c;
        @(negedge clk);
        c = cyc;
        cfg_wr = 1'b1; cfg_width = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        expect_at(c + 1, exp_code, 1'b1, tag);
    endtask

    initial begin
        int c;
        idle(2);
        boot(1'b1, 1'b1, 2'b10, "R2 high/high");
        boot(1'b0, 1'b0, 2'b01, "R3 low/low");
        boot(1'b0, 1'b1, 2'b00, "R4 tied to reset");
        boot(1'b1, 1'b0, 2'b10, "R5 high/low");
        boot(1'b1, 1'b1, 2'b10, "R1 strap level during reset");

        // R7, R8: override, then strap toggling is ignored
        cfg_write(2'b00, 2'b00, "R7 cfg 8-bit");
        strap_in = 1'b0; idle(2); strap_in = 1'b1; idle(2);
        expect_at(cyc + 1, 2'b00, 1'b1, "R8 strap ignored");
        idle(2);
        cfg_write(2'b01, 2'b01, "R7 cfg 16-bit");
        cfg_write(2'b11, 2'b10, "R9 cfg 11 maps to 32-bit");
        idle(2);

        // R8: reset restores strap decision
        boot(1'b0, 1'b0, 2'b01, "R8 reset drops override");

        // R7: write before the strap is observed
        @(negedge clk);
        rst = 1'b1; strap_in = 1'b1;
        idle(6);
        c = cyc;
        rst = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_width = 2'b01;
        @(negedge clk);
        cfg_wr = 1'b0;
        expect_at(c + 2, 2'b01, 1'b1, "R7 early cfg");
        expect_at(c + 4, 2'b01, 1'b1, "R8 late sample ignored");
        expect_at(c + 5, 2'b01, 1'b1, "R10 valid stays");
        idle(8);

        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R6: %0d expectations unmatched, expected 0", sb.size());
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R6: watchdog expired, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule